// File: doc/BRIEF.md
# Packed 8x8 Bit-Matrix Product and Transpose Unit

This unit reads each 64-bit operand as a square bit matrix of eight rows by eight columns, where byte r of the word holds row r and bit c within that byte holds column c. One registered stage computes one of three results, picked by a 2-bit operation code: the transpose of operand A, the product A times B over GF(2), where each result bit is the parity of a row-by-column AND, or the boolean product A times B, where each result bit is the OR of that AND.

A request is presented with `in_valid`. The result and `out_valid` appear on the clock edge that samples the request, one cycle later. When `in_valid` is low the result register keeps its last value and `out_valid` drops. The unit serves as the bit-matrix stage of a scalar bit-manipulation pipeline. Typical uses are bit-level permutations, linear maps over GF(2), and reachability steps on small adjacency matrices.

Top module: `bitmat_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first valid request, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` in a cycle equals `in_valid` in the previous cycle, so each accepted request gives exactly one result one cycle later.
- R3: With `op_sel` = 0 (transpose), result bit 8k+j equals operand A bit 8j+k for all j,k in 0..7.
- R4: With `op_sel` = 0, operand B has no effect on the result.
- R5: With `op_sel` = 1 (parity product), result bit 8r+c is the XOR over m of A bit 8r+m AND B bit 8m+c.
- R6: With `op_sel` = 2 (OR product), result bit 8r+c is 1 exactly when some m has A bit 8r+m and B bit 8m+c both set.
- R7: With `op_sel` = 3 (reserved), the result is all zeros.
- R8: In both product modes, a B operand of 0x8040201008040201 (the identity) returns A unchanged, and an A operand equal to the identity returns B unchanged.
- R9: In a cycle after one with `in_valid` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 transpose, 1 parity product, 2 OR product, 3 reserved |
| opnd_a | input | 64 | Left matrix A, byte r = row r |
| opnd_b | input | 64 | Right matrix B, byte r = row r |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Registered matrix result |

## Verification
Both products are driven with the identity on either side, which shows whether rows and columns are swapped or the bit order inside a byte is mirrored. Single-bit and all-ones operands separate parity accumulation from OR accumulation: for all-ones operands the parity product gives zero and the OR product gives all ones. Random operands are run in all four operation codes, with B changed alone during transposes and with idle gaps between requests, to expose operand leakage, reserved-code output and a result register that does not hold.

// File: rtl/bitmat_pkg.sv
package bitmat_pkg;
  localparam int unsigned MAT_DIM  = 8;
  localparam int unsigned MAT_BITS = MAT_DIM * MAT_DIM;

  typedef enum logic [1:0] {
    OP_FLIP  = 2'd0,
    OP_XPROD = 2'd1,
    OP_OPROD = 2'd2,
    OP_RSVD  = 2'd3
  } bm_op_e;

  // Identity matrix: row r carries only column r.
  function automatic logic [MAT_BITS-1:0] bm_identity();
    logic [MAT_BITS-1:0] v;
    v = '0;
    for (int r = 0; r < MAT_DIM; r++) v[r*MAT_DIM + r] = 1'b1;
    return v;
  endfunction

  // Boolean dot product of one row and one column, parity or OR reduced.
  function automatic logic bm_dot(input logic [MAT_DIM-1:0] row,
                                  input logic [MAT_DIM-1:0] col,
                                  input logic use_or);
    return use_or ? |(row & col) : ^(row & col);
  endfunction
endpackage

// File: rtl/bitmat_transpose.sv
module bitmat_transpose #(
  parameter int unsigned DIM = 8,
  localparam int unsigned NB = DIM * DIM
) (
  input  logic [NB-1:0] src,
  output logic [NB-1:0] dst
);
  for (genvar j = 0; j < DIM; j++) begin : g_row
    for (genvar k = 0; k < DIM; k++) begin : g_col
      assign dst[k*DIM + j] = src[j*DIM + k];
    end
  end
endmodule

// File: rtl/bitmat_product.sv
module bitmat_product
  import bitmat_pkg::*;
#(
  parameter int unsigned DIM    = 8,
  parameter bit          OR_ACC = 1'b0,
  localparam int unsigned NB    = DIM * DIM
) (
  input  logic [NB-1:0] rows_a,
  input  logic [NB-1:0] cols_b,   // B already transposed: byte c = column c
  output logic [NB-1:0] prod
);
  for (genvar r = 0; r < DIM; r++) begin : g_r
    for (genvar c = 0; c < DIM; c++) begin : g_c
      if (OR_ACC) begin : g_or
        assign prod[r*DIM + c] = bm_dot(rows_a[r*DIM +: DIM], cols_b[c*DIM +: DIM], 1'b1);
      end else begin : g_xor
        assign prod[r*DIM + c] = bm_dot(rows_a[r*DIM +: DIM], cols_b[c*DIM +: DIM], 1'b0);
      end
    end
  end
endmodule

// File: rtl/bitmat_unit.sv
module bitmat_unit
  import bitmat_pkg::*;
#(
  parameter int unsigned DIM = 8,
  localparam int unsigned NB = DIM * DIM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op_sel,
  input  logic [NB-1:0] opnd_a,
  input  logic [NB-1:0] opnd_b,
  output logic          out_valid,
  output logic [NB-1:0] result
);
  logic [NB-1:0] a_flip;
  logic [NB-1:0] b_cols;
  logic [NB-1:0] xor_prod;
  logic [NB-1:0] or_prod;
  logic [NB-1:0] next_res;

  bitmat_transpose #(.DIM(DIM)) u_flip_a (.src(opnd_a), .dst(a_flip));
  bitmat_transpose #(.DIM(DIM)) u_flip_b (.src(opnd_b), .dst(b_cols));

  bitmat_product #(.DIM(DIM), .OR_ACC(1'b0)) u_xprod (
    .rows_a(opnd_a), .cols_b(b_cols), .prod(xor_prod));
  bitmat_product #(.DIM(DIM), .OR_ACC(1'b1)) u_oprod (
    .rows_a(opnd_a), .cols_b(b_cols), .prod(or_prod));

  always_comb begin
    unique case (bm_op_e'(op_sel))
      OP_FLIP:  next_res = a_flip;
      OP_XPROD: next_res = xor_prod;
      OP_OPROD: next_res = or_prod;
      default:  next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/bitmat_unit_chk.sv
module bitmat_unit_chk
  import bitmat_pkg::*;
#(
  parameter int unsigned DIM = 8,
  localparam int unsigned NB = DIM * DIM
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    op_sel,
  input logic [NB-1:0] opnd_a,
  input logic [NB-1:0] opnd_b,
  input logic          out_valid,
  input logic [NB-1:0] result
);
  logic [NB-1:0] ident;
  assign ident = bm_identity();

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd3) |=> (result == '0));
  p_ident_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 2'd1 || op_sel == 2'd2) && opnd_b == ident)
      |=> (result == $past(opnd_a)));
  p_ident_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 2'd1 || op_sel == 2'd2) && opnd_a == ident)
      |=> (result == $past(opnd_b)));
  p_flip_corner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd0)
      |=> (result[1] == $past(opnd_a[DIM]) && result[NB-1] == $past(opnd_a[NB-1])));
  p_zero_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 2'd1 || op_sel == 2'd2) && opnd_a == '0)
      |=> (result == '0));
endmodule

bind bitmat_unit bitmat_unit_chk #(.DIM(DIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

// File: tb/bitmat_unit_tb_top.sv
module bitmat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fails  = 0;

  logic        exp_valid = 1'b0;
  logic [63:0] exp_res   = '0;

  localparam logic [63:0] IDENT = 64'h8040201008040201;

  always #10 clk = ~clk;

  bitmat_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

  function automatic logic [63:0] model(input logic [1:0] op,
                                        input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    if (op == 2'd0) begin
      for (int row = 0; row < 8; row++)
        for (int col = 0; col < 8; col++)
          r[col*8 + row] = a[row*8 + col];
    end else if (op == 2'd1 || op == 2'd2) begin
      for (int i = 0; i < 64; i++) begin
        int hits;
        hits = 0;
        for (int m = 0; m < 8; m++)
          if (a[(i/8)*8 + m] && b[m*8 + (i%8)]) hits++;
        r[i] = (op == 2'd1) ? hits[0] : (hits != 0);
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at the negedge, compare at the following negedge.
  task automatic step(input string tag, input logic v, input logic [1:0] op,
                      input logic [63:0] a, input logic [63:0] b);
    in_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
    exp_valid = v;
    if (v) exp_res = model(op, a, b);
    @(negedge clk);
    check({tag, " R2 valid"}, {63'd0, out_valid}, {63'd0, exp_valid});
    check(tag, result, exp_res);
  endtask

  initial begin
    #1_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb, first;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", result, 64'd0);

    step("R3 flip single", 1'b1, 2'd0, 64'h0000_0000_0000_0100, 64'd0);
    step("R3 flip pattern", 1'b1, 2'd0, 64'h0123_4567_89AB_CDEF, 64'd0);
    ra = {$urandom, $urandom};
    step("R4 flip b=0", 1'b1, 2'd0, ra, 64'd0);
    first = result;
    step("R4 flip b=ones", 1'b1, 2'd0, ra, '1);
    check("R4 b ignored", result, first);

    step("R8 xor ident b", 1'b1, 2'd1, 64'hDEAD_BEEF_0BAD_F00D, IDENT);
    step("R8 or ident b", 1'b1, 2'd2, 64'hDEAD_BEEF_0BAD_F00D, IDENT);
    step("R8 xor ident a", 1'b1, 2'd1, IDENT, 64'h1357_9BDF_2468_ACE0);
    step("R8 or ident a", 1'b1, 2'd2, IDENT, 64'h1357_9BDF_2468_ACE0);

    step("R5 xor all ones", 1'b1, 2'd1, '1, '1);
    step("R6 or all ones", 1'b1, 2'd2, '1, '1);
    step("R5 xor single", 1'b1, 2'd1, 64'h0000_0000_0000_0004, 64'h0000_0000_0080_0000);
    step("R6 or single", 1'b1, 2'd2, 64'h0000_0000_0000_0004, 64'h0000_0000_0080_0000);

    step("R7 rsvd", 1'b1, 2'd3, '1, '1);
    step("R9 idle after rsvd", 1'b0, 2'd1, '1, IDENT);

    for (int n = 0; n < 40; n++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      step($sformatf("R5 R6 R3 R7 random op%0d", n % 4), 1'b1, 2'(n % 4), ra, rb);
      if (n % 5 == 0) step("R9 idle hold", 1'b0, 2'(n % 3), rb, ra);
    end
    step("R9 final idle", 1'b0, 2'd0, 64'd0, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule